// File: doc/BRIEF.md
# Interval Conflict Matrix Accumulator

This block watches a stream of configuration identifiers, one per accepted cycle, and builds an N by N matrix of counts. Entry [i][j] tells how many of the gaps between two back-to-back occurrences of identifier i held identifier j at least once. A tool that later decides which configurations may share a context reads the matrix and learns which pairs keep interrupting one another.

For each identifier the block keeps one bit per other identifier. The bit means "seen since this identifier last arrived". When an identifier arrives again, a walker steps across its row once. For each marked column it adds one to the matching counter, and it spends exactly N cycles doing this. The input is held off with a ready signal while the walk runs. When the stream has ended, any entry can be read back by giving its row and column. A synchronous clear empties the matrix, all tracking state and any walk in progress.

Top module: `icm_accum`

## Requirements
- R1: After reset, and in the cycle after `clear_i` is high, every matrix entry reads 0 and every identifier counts as never seen.
- R2: When identifier i is accepted and i has been accepted before, entry [i][j] increases by one for every identifier j that was accepted at least once since the previous acceptance of i.
- R3: If j is accepted several times inside one gap between occurrences of i, entry [i][j] still increases by exactly one for that gap.
- R4: The first acceptance of an identifier since reset or clear changes no matrix entry.
- R5: A single accepted identifier j marks itself in the tracking row of every identifier that has already been seen, so a later repeat of any of those identifiers counts j.
- R6: Counters saturate at 2^CNT_W-1 and never wrap.
- R7: After an accepted identifier whose row holds at least one mark, `id_ready_o` is low for exactly NUM_IDS cycles and then returns high. In every other case it stays high. No identifier is taken while it is low.
- R8: An identifier value of NUM_IDS or more is accepted and then dropped. It changes no entry and no tracking state, and it does not lower ready.
- R9: `rd_data_o` shows entry [`rd_row_i`][`rd_col_i`] one cycle after the address is presented. A row or column of NUM_IDS or more reads 0.
- R10: Diagonal entries [i][i] always stay 0, even when an identifier repeats back-to-back.
- R11: A clear that arrives during a walk abandons the walk, so ready is high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clear_i | input | 1 | Synchronous clear of matrix and tracking state |
| id_valid_i | input | 1 | Identifier on `id_i` is valid |
| id_i | input | ID_W | Configuration identifier |
| id_ready_o | output | 1 | Block can take an identifier this cycle |
| rd_row_i | input | ID_W | Read row (first identifier) |
| rd_col_i | input | ID_W | Read column (second identifier) |
| rd_data_o | output | CNT_W | Count at the selected entry, one cycle later |

## Verification
The bench repeats a column several times inside one gap. A design that counted occurrences rather than gaps would report a value above one. It repeats an identifier back-to-back and reads the diagonal, which a design that marked an identifier in its own row would make nonzero. It alternates two identifiers past the counter limit, so a wrapping counter shows a small number in place of the maximum. It also sends out-of-range identifiers, which a design without a range guard would let corrupt row 0 or stall the input. It asserts clear in the middle of a walk, which a design that ignored clear would answer by keeping ready low.

// File: rtl/icm_pkg.sv
package icm_pkg;
   function automatic int unsigned id_width(input int unsigned n);
      int unsigned w;
      w = 1;
      while ((1 << w) < n) w++;
      return w;
   endfunction
endpackage

// File: rtl/icm_track.sv
module icm_track
   import icm_pkg::*;
#(
   parameter int unsigned NUM_IDS = 8,
   localparam int unsigned ID_W = id_width(NUM_IDS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear_i,
   input  logic               take_i,
   input  logic [ID_W-1:0]    id_i,
   output logic               in_range_o,
   output logic [NUM_IDS-1:0] pend_o
);
   logic [NUM_IDS-1:0] open_q;
   logic [NUM_IDS-1:0] mark_q [NUM_IDS];
   logic               hit;

   always_comb begin
      in_range_o = 1'b0;
      pend_o     = '0;
      for (int i = 0; i < NUM_IDS; i++) begin
         if (id_i == ID_W'(i)) begin
            in_range_o = 1'b1;
            pend_o     = mark_q[i];
         end
      end
   end

   assign hit = take_i && in_range_o;

   for (genvar r = 0; r < NUM_IDS; r++) begin : g_row
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            open_q[r] <= 1'b0;
            mark_q[r] <= '0;
         end else if (clear_i) begin
            open_q[r] <= 1'b0;
            mark_q[r] <= '0;
         end else if (hit) begin
            if (id_i == ID_W'(r)) begin
               open_q[r] <= 1'b1;
               mark_q[r] <= '0;
            end else if (open_q[r]) begin
               for (int c = 0; c < NUM_IDS; c++) begin
                  if (id_i == ID_W'(c)) mark_q[r][c] <= 1'b1;
               end
            end
         end
      end
   end
endmodule

// File: rtl/icm_walker.sv
module icm_walker
   import icm_pkg::*;
#(
   parameter int unsigned NUM_IDS = 8,
   localparam int unsigned ID_W = id_width(NUM_IDS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear_i,
   input  logic               start_i,
   input  logic [ID_W-1:0]    row_i,
   input  logic [NUM_IDS-1:0] pend_i,
   output logic               busy_o,
   output logic               inc_o,
   output logic [ID_W-1:0]    inc_row_o,
   output logic [ID_W-1:0]    inc_col_o
);
   localparam logic [ID_W-1:0] LAST_COL = ID_W'(NUM_IDS - 1);

   logic               busy_q;
   logic [ID_W-1:0]    col_q;
   logic [ID_W-1:0]    row_q;
   logic [NUM_IDS-1:0] mask_q;
   logic               cur_bit;

   always_comb begin
      cur_bit = 1'b0;
      for (int c = 0; c < NUM_IDS; c++) begin
         if (col_q == ID_W'(c)) cur_bit = mask_q[c];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         col_q  <= '0;
         row_q  <= '0;
         mask_q <= '0;
      end else if (clear_i) begin
         busy_q <= 1'b0;
         col_q  <= '0;
         mask_q <= '0;
      end else if (busy_q) begin
         if (col_q == LAST_COL) begin
            busy_q <= 1'b0;
            col_q  <= '0;
         end else begin
            col_q <= col_q + 1'b1;
         end
      end else if (start_i && (|pend_i)) begin
         busy_q <= 1'b1;
         col_q  <= '0;
         row_q  <= row_i;
         mask_q <= pend_i;
      end
   end

   assign busy_o    = busy_q;
   assign inc_o     = busy_q && cur_bit;
   assign inc_row_o = row_q;
   assign inc_col_o = col_q;
endmodule

// File: rtl/icm_counters.sv
module icm_counters
   import icm_pkg::*;
#(
   parameter int unsigned NUM_IDS  = 8,
   parameter int unsigned CNT_W    = 8,
   parameter bit          READ_REG = 1'b1,
   localparam int unsigned ID_W    = id_width(NUM_IDS),
   localparam int unsigned ENTRIES = NUM_IDS * NUM_IDS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             inc_i,
   input  logic [ID_W-1:0]  inc_row_i,
   input  logic [ID_W-1:0]  inc_col_i,
   input  logic [ID_W-1:0]  rd_row_i,
   input  logic [ID_W-1:0]  rd_col_i,
   output logic [CNT_W-1:0] rd_data_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] cnt_q [ENTRIES];
   logic [CNT_W-1:0] rd_val;

   for (genvar e = 0; e < ENTRIES; e++) begin : g_cnt
      localparam int unsigned ROW = e / NUM_IDS;
      localparam int unsigned COL = e % NUM_IDS;
      logic sel;
      assign sel = inc_i && (inc_row_i == ID_W'(ROW)) && (inc_col_i == ID_W'(COL));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          cnt_q[e] <= '0;
         else if (clear_i)                    cnt_q[e] <= '0;
         else if (sel && (cnt_q[e] != CNT_MAX)) cnt_q[e] <= cnt_q[e] + 1'b1;
      end
   end

   always_comb begin
      rd_val = '0;
      for (int k = 0; k < ENTRIES; k++) begin
         if ((rd_row_i == ID_W'(k / NUM_IDS)) && (rd_col_i == ID_W'(k % NUM_IDS)))
            rd_val = cnt_q[k];
      end
   end

   if (READ_REG) begin : g_rd_reg
      logic [CNT_W-1:0] rd_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rd_q <= '0;
         else        rd_q <= rd_val;
      end
      assign rd_data_o = rd_q;
   end else begin : g_rd_comb
      assign rd_data_o = rd_val;
   end
endmodule

// File: rtl/icm_accum.sv
module icm_accum
   import icm_pkg::*;
#(
   parameter int unsigned NUM_IDS  = 8,
   parameter int unsigned CNT_W    = 8,
   parameter bit          READ_REG = 1'b1,
   localparam int unsigned ID_W    = id_width(NUM_IDS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             id_valid_i,
   input  logic [ID_W-1:0]  id_i,
   output logic             id_ready_o,
   input  logic [ID_W-1:0]  rd_row_i,
   input  logic [ID_W-1:0]  rd_col_i,
   output logic [CNT_W-1:0] rd_data_o
);
   if (NUM_IDS < 2) begin : g_bad_ids
      $error("icm_accum: NUM_IDS must be at least 2");
   end
   if (NUM_IDS > 64) begin : g_big_ids
      $error("icm_accum: NUM_IDS above 64 makes the counter array too large");
   end
   if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt
      $error("icm_accum: CNT_W must lie in 1..32");
   end

   logic               take;
   logic               in_range;
   logic [NUM_IDS-1:0] pend;
   logic               busy;
   logic               inc;
   logic [ID_W-1:0]    inc_row;
   logic [ID_W-1:0]    inc_col;

   assign id_ready_o = !busy;
   assign take       = id_valid_i && !busy && !clear_i;

   icm_track #(.NUM_IDS(NUM_IDS)) u_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear_i   (clear_i),
      .take_i    (take),
      .id_i      (id_i),
      .in_range_o(in_range),
      .pend_o    (pend)
   );

   icm_walker #(.NUM_IDS(NUM_IDS)) u_walk (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear_i  (clear_i),
      .start_i  (take && in_range),
      .row_i    (id_i),
      .pend_i   (pend),
      .busy_o   (busy),
      .inc_o    (inc),
      .inc_row_o(inc_row),
      .inc_col_o(inc_col)
   );

   icm_counters #(.NUM_IDS(NUM_IDS), .CNT_W(CNT_W), .READ_REG(READ_REG)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear_i  (clear_i),
      .inc_i    (inc),
      .inc_row_i(inc_row),
      .inc_col_i(inc_col),
      .rd_row_i (rd_row_i),
      .rd_col_i (rd_col_i),
      .rd_data_o(rd_data_o)
   );
endmodule

// File: rtl/icm_accum_chk.sv
module icm_accum_chk
   import icm_pkg::*;
#(
   parameter int unsigned NUM_IDS  = 8,
   parameter int unsigned CNT_W    = 8,
   parameter bit          READ_REG = 1'b1,
   localparam int unsigned ID_W    = id_width(NUM_IDS)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             clear_i,
   input logic             id_valid_i,
   input logic [ID_W-1:0]  id_i,
   input logic             id_ready_o,
   input logic [ID_W-1:0]  rd_row_i,
   input logic [ID_W-1:0]  rd_col_i,
   input logic [CNT_W-1:0] rd_data_o
);
   logic [7:0] low_run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           low_run_q <= '0;
      else if (!id_ready_o) low_run_q <= low_run_q + 1'b1;
      else                  low_run_q <= '0;
   end

   a_r7_stall_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(low_run_q) <= NUM_IDS));

   a_r7_stall_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(id_ready_o) |-> $past(id_valid_i && !clear_i));

   a_r11_clear_frees: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> id_ready_o);

   if (READ_REG) begin : g_reg
      a_r9_oob_zero: assert property (@(posedge clk) disable iff (!rst_n)
         ((int'(rd_row_i) >= NUM_IDS) || (int'(rd_col_i) >= NUM_IDS)) |=> (rd_data_o == '0));
      a_r10_diag_zero: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_row_i == rd_col_i) |=> (rd_data_o == '0));
   end else begin : g_comb
      a_r9_oob_zero: assert property (@(posedge clk) disable iff (!rst_n)
         ((int'(rd_row_i) >= NUM_IDS) || (int'(rd_col_i) >= NUM_IDS)) |-> (rd_data_o == '0));
      a_r10_diag_zero: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_row_i == rd_col_i) |-> (rd_data_o == '0));
   end
endmodule

bind icm_accum icm_accum_chk #(.NUM_IDS(NUM_IDS), .CNT_W(CNT_W), .READ_REG(READ_REG)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .clear_i   (clear_i),
   .id_valid_i(id_valid_i),
   .id_i      (id_i),
   .id_ready_o(id_ready_o),
   .rd_row_i  (rd_row_i),
   .rd_col_i  (rd_col_i),
   .rd_data_o (rd_data_o)
);

// File: tb/icm_accum_test.sv
`timescale 1ns/1ps
module icm_accum_test;
   localparam int N    = 6;
   localparam int CW   = 4;
   localparam int IW   = 3;
   localparam int CMAX = 15;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          clear = 1'b0;
   logic          vld = 1'b0;
   logic [IW-1:0] id = '0;
   logic          rdy;
   logic [IW-1:0] rrow = '0;
   logic [IW-1:0] rcol = '0;
   logic [CW-1:0] rdata;

   always #2.5 clk = ~clk;

   icm_accum #(.NUM_IDS(N), .CNT_W(CW), .READ_REG(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .clear_i(clear), .id_valid_i(vld), .id_i(id),
      .id_ready_o(rdy), .rd_row_i(rrow), .rd_col_i(rcol), .rd_data_o(rdata)
   );

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   int exp_m  [N][N];
   bit seen_m [N][N];
   bit open_m [N];

   int    q_exp [$];
   int    q_r   [$];
   int    q_c   [$];
   string q_tag [$];
   bit    rd_go = 1'b0;

   task automatic check(input bit ok, input string tag, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   task automatic model_clear();
      for (int i = 0; i < N; i++) begin
         open_m[i] = 1'b0;
         for (int j = 0; j < N; j++) begin
            exp_m[i][j] = 0;
            seen_m[i][j] = 1'b0;
         end
      end
   endtask

   // Drives one identifier, updates the model, and checks the stall length (R7).
   task automatic send(input int v, input bit measure);
      int stall_exp;
      int stall;
      stall_exp = 0;
      @(negedge clk);
      while (!rdy) @(negedge clk);
      vld = 1'b1;
      id  = IW'(v);
      if (v < N) begin
         if (open_m[v]) begin
            for (int j = 0; j < N; j++) begin
               if (seen_m[v][j]) begin
                  stall_exp = N;
                  if (exp_m[v][j] < CMAX) exp_m[v][j]++;
               end
            end
         end
         for (int j = 0; j < N; j++) seen_m[v][j] = 1'b0;
         for (int i = 0; i < N; i++) if (i != v && open_m[i]) seen_m[i][v] = 1'b1;
         open_m[v] = 1'b1;
      end
      @(posedge clk);
      @(negedge clk);
      vld = 1'b0;
      if (measure) begin
         stall = 0;
         while (!rdy && stall < 4 * N) begin
            stall++;
            @(negedge clk);
         end
         check(stall == stall_exp, "R7/R8 stall length", stall, stall_exp);
      end
   endtask

   task automatic issue_read(input int r, input int c, input int expv, input string tag);
      @(negedge clk);
      rrow = IW'(r);
      rcol = IW'(c);
      q_exp.push_back(expv);
      q_r.push_back(r);
      q_c.push_back(c);
      q_tag.push_back(tag);
      rd_go = 1'b1;
   endtask

   task automatic read_all(input string tag);
      for (int r = 0; r < N; r++)
         for (int c = 0; c < N; c++)
            issue_read(r, c, exp_m[r][c], tag);
      issue_read(7, 0, 0, "R9 row out of range");
      issue_read(1, 6, 0, "R9 column out of range");
      @(negedge clk);
      rd_go = 1'b0;
      while (q_exp.size() != 0) @(negedge clk);
   endtask

   task automatic do_clear();
      @(negedge clk);
      clear = 1'b1;
      @(negedge clk);
      clear = 1'b0;
      model_clear();
   endtask

   // Monitor: pops the expected value for each read captured at the edge.
   initial begin
      forever begin
         @(posedge clk);
         if (rd_go) begin
            #1;
            if (q_exp.size() != 0) begin
               int e;
               int r;
               int c;
               string t;
               e = q_exp.pop_front();
               r = q_r.pop_front();
               c = q_c.pop_front();
               t = q_tag.pop_front();
               check(int'(rdata) == e, $sformatf("%s [%0d][%0d]", t, r, c), int'(rdata), e);
            end
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int lfsr;
      model_clear();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(rdy == 1'b1, "R1 ready after reset", int'(rdy), 1);
      read_all("R1 reset zero");

      // R2 R3 R5: 0 1 2 1 1 0, then 2 closes a gap holding 1 and 0
      send(0, 1); send(1, 1); send(2, 1); send(1, 1); send(1, 1); send(0, 1); send(2, 1);
      read_all("R2/R3/R5 basic");

      // R1 clear, then R4 first occurrences only
      do_clear();
      read_all("R1 after clear");
      send(3, 1); send(4, 1); send(5, 1);
      read_all("R4 first occurrence");

      // R10 back-to-back repeats
      do_clear();
      send(2, 1); send(2, 1); send(2, 1);
      read_all("R10 diagonal");

      // R8 out-of-range identifiers
      do_clear();
      send(0, 1); send(7, 1); send(0, 1); send(6, 1); send(1, 1); send(0, 1);
      read_all("R8 out of range");

      // R6 saturation
      do_clear();
      for (int k = 0; k < 24; k++) begin
         send(0, 1);
         send(1, 1);
      end
      check(exp_m[0][1] == CMAX, "R6 model saturates", exp_m[0][1], CMAX);
      read_all("R6 saturation");

      // R11 clear in the middle of a walk
      do_clear();
      send(0, 1); send(1, 1); send(0, 0);
      check(rdy == 1'b0, "R11 walk started", int'(rdy), 0);
      clear = 1'b1;
      @(negedge clk);
      clear = 1'b0;
      model_clear();
      check(rdy == 1'b1, "R11 ready after clear", int'(rdy), 1);
      read_all("R11 cleared");

      // Mixed stream (R2 R3 R5 R6)
      lfsr = 32'h5a5;
      for (int k = 0; k < 150; k++) begin
         lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'h8016 : 0);
         send(lfsr % 7, 1);
      end
      read_all("R2/R5 mixed stream");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule